// File: doc/BRIEF.md
# Pseudo-SRAM Controller with Hidden Refresh

This block lets a host treat a refresh-dependent, row/column-addressed storage core as if it were a plain static RAM. The host drives a select, a write flag, an address and write data. A `ready` output tells the host when a request can be taken. A one-cycle `done` pulse marks completion, and read data is valid while `done` is high. The host never sees row or column strobes and never asks for refresh.

Inside the block, each accepted address is split into a row part (upper bits) and a column part (lower bits). A sequencer strobes the row into the core and then strobes the column. The row stays open afterwards, so a later access to the same row skips the row phase and takes a short page path. An interval timer requests refresh. A refresh runs when the controller is idle and the host is not selecting it. It walks through the rows in order and closes the open row. If the host keeps the controller busy for two whole intervals, the overdue refresh preempts the next host access.

All cycle counts are parameters: random access 7 cycles, page access 3 cycles, refresh 5 cycles. The default interval is 64 cycles. The array is 2^ROW_W rows by 2^COL_W words. The defaults are small so the project elaborates quickly; the widths scale up to a 2M x 16 array.

Top module: `psram_wrap`

## Requirements
- R1: After reset `ready` is 1 and `done` is 0, and no row is treated as open.
- R2: A read returns the data most recently written to the same address, on `rdata` while `done` is high.
- R3: An accepted access whose row differs from the open row, or when no row is open, raises `done` exactly RAND_LAT clock edges after the accepting edge (the edge where `cs` and `ready` are both 1).
- R4: An accepted access to the open row raises `done` exactly PAGE_LAT edges after the accepting edge.
- R5: Each accepted access produces exactly one single-cycle `done` pulse, and `ready` is 0 in the cycle after an accepting edge.
- R6: With the host idle, a refresh starts in at least every REF_INTERVAL cycles. Each refresh holds `ready` at 0 for exactly REF_LAT cycles.
- R7: After any refresh, the next access is a row miss and takes RAND_LAT cycles, even when it targets the row that was open before.
- R8: Under back-to-back host traffic, refresh is never postponed by more than two intervals. The start of one refresh is at most 2*REF_INTERVAL + RAND_LAT + 2 cycles after the start of the previous one. While a refresh is overdue, `ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Host select; an access is taken on an edge where `cs` and `ready` are both 1 |
| we | input | 1 | 1 = write, 0 = read; sampled with the access |
| addr | input | ROW_W+COL_W | Word address; upper ROW_W bits are the row, lower COL_W bits the column |
| wdata | input | DATA_W | Write data; sampled with the access |
| rdata | output | DATA_W | Read data; valid while `done` is high after a read |
| ready | output | 1 | Controller can take an access this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following: an accepted access drops `ready`, a `done` always follows a column strobe by two cycles, no column strobe occurs during refresh, an overdue refresh keeps the host out, the pending count stays bounded, and the refresh row pointer moves only through refresh. Other properties need the bench's scenarios to show them, because they depend on history seen at the ports. These are the page-hit against row-miss latencies, the forced miss after a refresh, read-after-write data across rows, the exact refresh length when idle, and the bound on refresh spacing under saturating traffic.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_REF  = 2'd2
    } seq_state_e;

    // Largest of three cycle counts, used to size the phase counter.
    function automatic int unsigned lat_max(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Width needed to hold values 0..n (at least 1).
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/psram_ref_timer.sv
module psram_ref_timer #(
    parameter int unsigned INTERVAL = 64,
    parameter int unsigned MAX_PEND = 2,
    localparam int unsigned CW = psram_pkg::width_for(INTERVAL - 1),
    localparam int unsigned PW = psram_pkg::width_for(MAX_PEND)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_start,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic [PW-1:0] pend
);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);
    localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);

    logic [CW-1:0] tcnt;
    logic          tick;

    assign tick = (tcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            case ({tick, ref_start})
                2'b10:   if (pend != PMAX) pend <= pend + 1'b1;
                2'b01:   if (pend != '0) pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    assign ref_req    = (pend != '0);
    assign ref_urgent = (pend >= PMAX);

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned ROW_W    = 5,
    parameter int unsigned COL_W    = 5,
    parameter int unsigned RAND_LAT = 7,
    parameter int unsigned PAGE_LAT = 3,
    parameter int unsigned REF_LAT  = 5,
    localparam int unsigned ADDR_W  = ROW_W + COL_W,
    localparam int unsigned CNT_W   = width_for(lat_max(RAND_LAT, PAGE_LAT, REF_LAT))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ref_req,
    input  logic              ref_urgent,
    output logic              ready,
    output logic              accept,
    output logic              ref_start,
    output logic              row_stb,
    output logic [ROW_W-1:0]  row_addr,
    output logic              col_stb,
    output logic [COL_W-1:0]  col_addr,
    output logic              core_we,
    output logic              done,
    output logic [ROW_W-1:0]  ref_row,
    output seq_state_e        state
);
    typedef logic [CNT_W-1:0] cnt_t;

    cnt_t             cnt;
    logic             first;
    logic             need_row;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic             cur_we;
    logic             open_v;
    logic [ROW_W-1:0] open_row;
    logic [ROW_W-1:0] a_row;
    logic             hit;

    assign a_row     = addr[ADDR_W-1:COL_W];
    assign hit       = open_v && (a_row == open_row);
    assign ready     = (state == ST_IDLE) && !ref_urgent;
    assign accept    = cs && ready;
    assign ref_start = (state == ST_IDLE) && !accept && ref_req;

    // Strobes toward the core
    assign row_stb  = first && (((state == ST_ACC) && need_row) || (state == ST_REF));
    assign row_addr = (state == ST_REF) ? ref_row : cur_row;
    assign col_stb  = (state == ST_ACC) && (cnt == cnt_t'(1));
    assign col_addr = cur_col;
    assign core_we  = cur_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            first    <= 1'b0;
            need_row <= 1'b0;
            cur_row  <= '0;
            cur_col  <= '0;
            cur_we   <= 1'b0;
            open_v   <= 1'b0;
            open_row <= '0;
            ref_row  <= '0;
            done     <= 1'b0;
        end else begin
            done  <= 1'b0;
            first <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_ACC;
                        first    <= 1'b1;
                        cur_row  <= a_row;
                        cur_col  <= addr[COL_W-1:0];
                        cur_we   <= we;
                        need_row <= !hit;
                        cnt      <= hit ? cnt_t'(PAGE_LAT - 1) : cnt_t'(RAND_LAT - 1);
                        open_v   <= 1'b1;
                        open_row <= a_row;
                    end else if (ref_start) begin
                        state  <= ST_REF;
                        first  <= 1'b1;
                        cnt    <= cnt_t'(REF_LAT - 1);
                        open_v <= 1'b0;
                    end
                end
                ST_ACC: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_REF: begin
                    if (cnt == '0) begin
                        state   <= ST_IDLE;
                        ref_row <= ref_row + 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/psram_core.sv
module psram_core #(
    parameter int unsigned ROW_W  = 5,
    parameter int unsigned COL_W  = 5,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned DEPTH = 1 << (ROW_W + COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_stb,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic              col_stb,
    input  logic [COL_W-1:0]  col_addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [ROW_W-1:0]  latched_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched_row <= '0;
        end else if (row_stb) begin
            latched_row <= row_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (col_stb && we) begin
            cells[{latched_row, col_addr}] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (col_stb && !we) begin
            rdata <= cells[{latched_row, col_addr}];
        end
    end

endmodule

// File: rtl/psram_wrap.sv
module psram_wrap
    import psram_pkg::*;
#(
    parameter int unsigned ROW_W        = 5,
    parameter int unsigned COL_W        = 5,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned RAND_LAT     = 7,
    parameter int unsigned PAGE_LAT     = 3,
    parameter int unsigned REF_LAT      = 5,
    parameter int unsigned REF_INTERVAL = 64,
    parameter int unsigned MAX_PEND     = 2,
    localparam int unsigned ADDR_W      = ROW_W + COL_W,
    localparam int unsigned PW          = width_for(MAX_PEND)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              done
);
    logic              ref_req;
    logic              urgent;
    logic [PW-1:0]     pend;
    logic              accept;
    logic              ref_start;
    logic              row_stb;
    logic [ROW_W-1:0]  row_addr;
    logic              col_stb;
    logic [COL_W-1:0]  col_addr;
    logic              core_we;
    logic [ROW_W-1:0]  ref_row;
    seq_state_e        state;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (accept) begin
            wdata_q <= wdata;
        end
    end

    psram_ref_timer #(
        .INTERVAL (REF_INTERVAL),
        .MAX_PEND (MAX_PEND)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .ref_start  (ref_start),
        .ref_req    (ref_req),
        .ref_urgent (urgent),
        .pend       (pend)
    );

    psram_seq #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .RAND_LAT (RAND_LAT),
        .PAGE_LAT (PAGE_LAT),
        .REF_LAT  (REF_LAT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cs         (cs),
        .we         (we),
        .addr       (addr),
        .ref_req    (ref_req),
        .ref_urgent (urgent),
        .ready      (ready),
        .accept     (accept),
        .ref_start  (ref_start),
        .row_stb    (row_stb),
        .row_addr   (row_addr),
        .col_stb    (col_stb),
        .col_addr   (col_addr),
        .core_we    (core_we),
        .done       (done),
        .ref_row    (ref_row),
        .state      (state)
    );

    psram_core #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .row_stb  (row_stb),
        .row_addr (row_addr),
        .col_stb  (col_stb),
        .col_addr (col_addr),
        .we       (core_we),
        .wdata    (wdata_q),
        .rdata    (rdata)
    );

endmodule

// File: rtl/psram_wrap_chk.sv
module psram_wrap_chk
    import psram_pkg::*;
#(
    parameter int unsigned ROW_W    = 5,
    parameter int unsigned MAX_PEND = 2,
    localparam int unsigned PW      = width_for(MAX_PEND)
) (
    input logic             clk,
    input logic             rst,
    input logic             cs,
    input logic             ready,
    input logic             done,
    input logic             col_stb,
    input logic             urgent,
    input logic [PW-1:0]    pend,
    input logic [ROW_W-1:0] ref_row,
    input seq_state_e       state
);
    // R5
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && ready) |=> !ready);

    // R5
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_after_col_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(col_stb, 2));

    // R6
    ref_no_col_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REF) |-> !col_stb);

    // R6
    ref_row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_REF) |=> $stable(ref_row));

    // R8
    urgent_blocks_host_chk: assert property (@(posedge clk) disable iff (rst)
        urgent |-> !ready);

    // R8
    pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pend <= PW'(MAX_PEND));

endmodule

bind psram_wrap psram_wrap_chk #(
    .ROW_W    (ROW_W),
    .MAX_PEND (MAX_PEND)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .ready   (ready),
    .done    (done),
    .col_stb (col_stb),
    .urgent  (urgent),
    .pend    (pend),
    .ref_row (ref_row),
    .state   (state)
);

// File: tb/psram_wrap_test.sv
`timescale 1ns/1ps
module psram_wrap_test;
    localparam int ROW_W = 5, COL_W = 5, DATA_W = 16;
    localparam int RAND_LAT = 7, PAGE_LAT = 3, REF_LAT = 5, REF_INTERVAL = 64;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int GAP_BOUND = 2 * REF_INTERVAL + RAND_LAT + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic ready, done;

    always #2.5 clk = ~clk;

    psram_wrap uut (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .done(done)
    );

    typedef struct {
        bit          is_read;
        logic [15:0] data;
        int          lat;
        int          acc;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    logic [15:0] model [int];
    int  cyc = 0;
    int  checks = 0, fails = 0;
    int  outstanding = 0;
    bit  ref_seen = 0, open_v = 0, idle_phase = 0, finished = 0;
    int  open_row = 0;
    int  ref_run = 0, ref_starts = 0, last_ref_start = -1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Driver: present an access and push what it must produce.
    task automatic access(input bit w, input int a, input logic [15:0] d);
        exp_t e;
        int   row;
        bit   hit;
        @(negedge clk);
        cs = 1'b1; we = w; addr = ADDR_W'(a); wdata = d;
        while (!ready) @(negedge clk);
        row = a >> COL_W;
        hit = open_v && (open_row == row) && !ref_seen;
        e.is_read = !w;
        e.data    = w ? 16'h0 : model[a];
        e.lat     = hit ? PAGE_LAT : RAND_LAT;
        e.tag     = hit ? "R4" : ((open_v && open_row == row) ? "R7" : "R3");
        e.acc     = cyc + 1;
        if (w) model[a] = d;
        sbq.push_back(e);
        outstanding++;
        open_v = 1'b1; open_row = row; ref_seen = 1'b0;
        @(posedge clk);
        #1;
        check(!ready, "R5", "ready after accept", ready, 0);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cs = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare completions, watch refresh windows at the ports.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R5", "done without access", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(cyc - e.acc == e.lat, e.tag, "latency", cyc - e.acc, e.lat);
                    if (e.is_read) check(rdata == e.data, "R2", "read data", rdata, e.data);
                    outstanding--;
                end
            end
            if (outstanding == 0 && !ready) begin
                ref_seen = 1'b1;
                if (ref_run == 0) begin
                    ref_starts++;
                    if (last_ref_start >= 0)
                        check(cyc - last_ref_start <= GAP_BOUND, "R8", "refresh spacing",
                              cyc - last_ref_start, GAP_BOUND);
                    last_ref_start = cyc;
                end
                ref_run++;
            end else if (ref_run != 0) begin
                if (idle_phase) check(ref_run == REF_LAT, "R6", "refresh length", ref_run, REF_LAT);
                ref_run = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R5", "watchdog expired", cyc, 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        int s;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(ready == 1'b1, "R1", "ready after reset", ready, 1);
        check(done == 1'b0, "R1", "done after reset", done, 0);

        // Row 3 fill: first a miss, then page hits
        for (int c = 0; c < 4; c++) access(1'b1, (3 << COL_W) | c, 16'hA000 + 16'(c));
        for (int c = 3; c >= 0; c--) access(1'b0, (3 << COL_W) | c, 16'h0);
        access(1'b1, (7 << COL_W) | 5, 16'h5A5A);
        access(1'b0, (3 << COL_W) | 1, 16'h0);
        access(1'b0, (7 << COL_W) | 5, 16'h0);

        // Idle host: periodic refresh, then forced miss on the old row (R6, R7)
        idle(12);
        idle_phase = 1'b1;
        s = ref_starts;
        idle(3 * REF_INTERVAL);
        idle_phase = 1'b0;
        check(ref_starts - s >= 2, "R6", "refreshes while idle", ref_starts - s, 2);
        access(1'b0, (7 << COL_W) | 5, 16'h0);
        access(1'b0, (7 << COL_W) | 5, 16'h0);

        // Saturating traffic: refresh must still get through (R8)
        s = ref_starts;
        for (int i = 0; i < 50; i++) begin
            int a;
            a = (i * 37 + 5) % (1 << ADDR_W);
            access(1'b1, a, 16'(i * 911 + 3));
            access(1'b0, a, 16'h0);
        end
        check(ref_starts - s >= 2, "R8", "refreshes under load", ref_starts - s, 2);

        idle(20);
        check(sbq.size() == 0, "R5", "unanswered accesses", sbq.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule